// File: doc/BRIEF.md
# Audio Port Control and Status Register

This block is the control and status word for one direction (transmit or receive) of a serial audio port. Software reaches it through a single-word write/read port. It holds the port run request, a DMA request enable, a self-clearing FIFO pointer reset, a held soft reset, and one interrupt-enable bit per event flag. The serializer, the FIFO storage and the DMA engine are outside the block. They report events and levels into it, and they receive the run, FIFO reset, soft reset and DMA request outputs.

There are five flags. Three of them latch pulses and are cleared by writing one: word start, frame sync error, and FIFO error (underrun when transmitting, overflow when receiving). The other two are live views of the FIFO: the empty/full warning and the watermark request. Each flag's enable bit sits exactly eight bit positions below the flag. The interrupt line is the registered OR of all enabled flags.

After software drops the run request, the run status keeps reading as set until the serializer reports the end of the current frame. This lets software poll until the port has actually stopped.

Top module: `audio_port_csr`

## Requirements
- R1: After reset, with all event and level inputs low, `rd_data_o` reads 0 and `run_o`, `fifo_rst_o`, `soft_rst_o`, `dma_req_o` and `irq_o` are low.
- R2: Field layout: bit 31 is run, bit 25 is soft reset, bit 24 is FIFO reset, bit 0 is DMA enable, bits [12:8] are interrupt enables and bits [20:16] are flags. Flag index 0 is watermark, 1 is FIFO warning, 2 is FIFO error, 3 is sync error and 4 is word start. The enable for flag k is at bit 8+k. The enable bits read back as written and change only on a write.
- R3: A one-cycle pulse on a word-start, sync-error or FIFO-error input sets its flag (bits 20, 19, 18) in the next cycle. The flag stays set when a zero is written to it and clears after a write of one to its bit.
- R4: When a write of one to a sticky flag and a new event for that flag fall in the same cycle, the flag is set afterwards.
- R5: The watermark and warning flags (bits 16, 17) show the current level inputs combinationally. Writes to these bits have no effect.
- R6: `irq_o` equals, one cycle later, the OR over k of flag k AND enable k.
- R7: Writing one to bit 24 makes `fifo_rst_o` high for exactly the following cycle. Bit 24 always reads 0.
- R8: Writing one to bit 25 holds `soft_rst_o` high until a write with bit 25 at zero. While it is held, the sticky flags, the run status and the DMA enable are cleared, new events are ignored, level flags read 0 and `dma_req_o` is low. The interrupt enables keep their value.
- R9: Writing one to bit 31 sets `run_o` and read bit 31 in the next cycle, and end-of-frame pulses do not clear it. After a write of zero, both stay high until the cycle after an `frame_end_i` pulse.
- R10: `dma_req_o` is high exactly when the DMA enable is set, the watermark input is high and soft reset is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control/status word |
| ev_word_start_i | input | 1 | Word-start event pulse |
| ev_sync_err_i | input | 1 | Frame sync error event pulse |
| ev_fifo_err_i | input | 1 | FIFO underrun/overflow event pulse |
| lvl_fifo_warn_i | input | 1 | FIFO empty/full warning level |
| lvl_wmark_i | input | 1 | FIFO watermark request level |
| frame_end_i | input | 1 | End-of-frame pulse from the serializer |
| run_o | output | 1 | Port run status to the serializer |
| fifo_rst_o | output | 1 | One-cycle FIFO pointer reset |
| soft_rst_o | output | 1 | Held soft reset of the direction logic |
| dma_req_o | output | 1 | Gated watermark DMA request |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle. A write-one clear of a sticky flag can coincide with a fresh event for that same flag. A write that drops the run request can coincide with the end-of-frame pulse. The bench drives the write strobe and the event or frame-end pulse on the same falling edge, both with the flag previously clear and previously set. It then judges the result from the flag bit and the run bit read back in the following cycle: the event must win, and the run status must fall at once. A near-exhaustive sweep over all 32 enable masks and all 32 flag patterns checks the interrupt against the arithmetic OR of flag and enable.

// File: rtl/acsr_pkg.sv
package acsr_pkg;
    localparam int DATA_W       = 32;
    localparam int NUM_FLAGS    = 5;
    localparam int IE_LSB       = 8;
    localparam int FLAG_SHIFT   = 8;
    localparam int FLAG_LSB     = IE_LSB + FLAG_SHIFT;
    localparam int DMA_EN_BIT   = 0;
    localparam int FIFO_RST_BIT = 24;
    localparam int SOFT_RST_BIT = 25;
    localparam int RUN_BIT      = 31;

    // flag indices inside the flag field
    localparam int F_WMARK  = 0;
    localparam int F_WARN   = 1;
    localparam int F_FERR   = 2;
    localparam int F_SERR   = 3;
    localparam int F_WSTART = 4;

    localparam logic [NUM_FLAGS-1:0] STICKY_MASK =
        NUM_FLAGS'((1 << F_FERR) | (1 << F_SERR) | (1 << F_WSTART));

    localparam logic [DATA_W-1:0] WR_USED_MASK =
        (DATA_W'(1) << RUN_BIT) | (DATA_W'(1) << SOFT_RST_BIT) |
        (DATA_W'(1) << FIFO_RST_BIT) | (DATA_W'(1) << DMA_EN_BIT) |
        (DATA_W'((1 << NUM_FLAGS) - 1) << IE_LSB) |
        (DATA_W'((1 << NUM_FLAGS) - 1) << FLAG_LSB);

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/acsr_flag_bank.sv
module acsr_flag_bank
    import acsr_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      soft_rst_i,
    input  flag_vec_t clear_i,
    input  flag_vec_t src_i,
    output flag_vec_t flags_o
);
    typedef struct packed {
        flag_vec_t sticky;
    } bank_t;

    bank_t bank_d, bank_q;

    // next state: event wins over a same-cycle clear, soft reset wins over all
    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            bank_d.sticky[i] = STICKY_MASK[i] & ~soft_rst_i &
                               ((bank_q.sticky[i] & ~clear_i[i]) | src_i[i]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    // level flags are shown live, sticky flags from storage
    always_comb begin
        for (int i = 0; i < NUM_FLAGS; i++) begin
            flags_o[i] = STICKY_MASK[i] ? bank_q.sticky[i]
                                        : (src_i[i] & ~soft_rst_i);
        end
    end
endmodule

// File: rtl/acsr_run_ctl.sv
module acsr_run_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic soft_rst_i,
    input  logic wr_i,
    input  logic req_i,
    input  logic frame_end_i,
    output logic active_o
);
    typedef struct packed {
        logic req;
        logic act;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (soft_rst_i) begin
            run_d.req = 1'b0;
        end else if (wr_i) begin
            run_d.req = req_i;
        end
        // active persists after the request drops, until the frame closes
        run_d.act = ~soft_rst_i & (run_d.req | (run_q.act & ~frame_end_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    assign active_o = run_q.act;
endmodule

// File: rtl/audio_port_csr.sv
module audio_port_csr
    import acsr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ev_word_start_i,
    input  logic              ev_sync_err_i,
    input  logic              ev_fifo_err_i,
    input  logic              lvl_fifo_warn_i,
    input  logic              lvl_wmark_i,
    input  logic              frame_end_i,
    output logic              run_o,
    output logic              fifo_rst_o,
    output logic              soft_rst_o,
    output logic              dma_req_o,
    output logic              irq_o
);
    typedef struct packed {
        flag_vec_t ie;
        logic      dma_en;
        logic      soft_rst;
        logic      fifo_rst;
        logic      irq;
    } csr_t;

    csr_t      csr_d, csr_q;
    flag_vec_t flag_src;
    flag_vec_t flag_clr;
    flag_vec_t flags;
    logic      active;
    logic      unused_wr_bits;

    always_comb begin
        flag_src           = '0;
        flag_src[F_WMARK]  = lvl_wmark_i;
        flag_src[F_WARN]   = lvl_fifo_warn_i;
        flag_src[F_FERR]   = ev_fifo_err_i;
        flag_src[F_SERR]   = ev_sync_err_i;
        flag_src[F_WSTART] = ev_word_start_i;
    end

    assign flag_clr = wr_en_i ? (wr_data_i[FLAG_LSB +: NUM_FLAGS] & STICKY_MASK) : '0;
    assign unused_wr_bits = ^(wr_data_i & ~WR_USED_MASK);

    acsr_flag_bank flag_bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (csr_q.soft_rst),
        .clear_i    (flag_clr),
        .src_i      (flag_src),
        .flags_o    (flags)
    );

    acsr_run_ctl run_ctl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (csr_q.soft_rst),
        .wr_i        (wr_en_i),
        .req_i       (wr_data_i[RUN_BIT]),
        .frame_end_i (frame_end_i),
        .active_o    (active)
    );

    always_comb begin
        csr_d          = csr_q;
        csr_d.fifo_rst = wr_en_i & wr_data_i[FIFO_RST_BIT];
        if (wr_en_i) begin
            csr_d.ie       = wr_data_i[IE_LSB +: NUM_FLAGS];
            csr_d.soft_rst = wr_data_i[SOFT_RST_BIT];
            csr_d.dma_en   = wr_data_i[DMA_EN_BIT];
        end
        if (csr_q.soft_rst) begin
            csr_d.dma_en = 1'b0;
        end
        csr_d.irq = |(flags & csr_q.ie);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) csr_q <= '0;
        else         csr_q <= csr_d;
    end

    always_comb begin
        rd_data_o                          = '0;
        rd_data_o[RUN_BIT]                 = active;
        rd_data_o[SOFT_RST_BIT]            = csr_q.soft_rst;
        rd_data_o[FLAG_LSB +: NUM_FLAGS]   = flags;
        rd_data_o[IE_LSB +: NUM_FLAGS]     = csr_q.ie;
        rd_data_o[DMA_EN_BIT]              = csr_q.dma_en;
    end

    assign run_o      = active;
    assign fifo_rst_o = csr_q.fifo_rst;
    assign soft_rst_o = csr_q.soft_rst;
    assign dma_req_o  = csr_q.dma_en & lvl_wmark_i & ~csr_q.soft_rst;
    assign irq_o      = csr_q.irq;
endmodule

// File: rtl/acsr_checker.sv
module acsr_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic       wr_frst_i,
    input logic [4:0] wr_clr_i,
    input logic       rd_run_i,
    input logic       rd_frst_i,
    input logic [4:0] rd_ie_i,
    input logic [4:0] rd_flags_i,
    input logic       rd_dma_i,
    input logic       lvl_wmark_i,
    input logic       frame_end_i,
    input logic       run_o,
    input logic       fifo_rst_o,
    input logic       soft_rst_o,
    input logic       dma_req_o,
    input logic       irq_o
);
    assert_ie_write_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_en_i) |-> $stable(rd_ie_i));

    assert_ferr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_flags_i[2]) |-> ($past(wr_en_i && wr_clr_i[2]) || $past(soft_rst_o)));

    assert_serr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_flags_i[3]) |-> ($past(wr_en_i && wr_clr_i[3]) || $past(soft_rst_o)));

    assert_wstart_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_flags_i[4]) |-> ($past(wr_en_i && wr_clr_i[4]) || $past(soft_rst_o)));

    assert_irq_registered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(rd_flags_i & rd_ie_i)));

    assert_fifo_rst_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_rst_o |-> $past(wr_en_i && wr_frst_i));

    assert_fifo_rst_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_frst_i == 1'b0);

    assert_soft_rst_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_o && $past(soft_rst_o)) |-> (!rd_run_i && rd_flags_i[4:2] == 3'b000 && !rd_dma_i));

    assert_run_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(run_o) |-> ($past(frame_end_i) || $past(soft_rst_o)));

    assert_dma_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_req_o |-> (lvl_wmark_i && !soft_rst_o && rd_dma_i));
endmodule

bind audio_port_csr acsr_checker chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_frst_i   (wr_data_i[acsr_pkg::FIFO_RST_BIT]),
    .wr_clr_i    (wr_data_i[acsr_pkg::FLAG_LSB +: acsr_pkg::NUM_FLAGS]),
    .rd_run_i    (rd_data_o[acsr_pkg::RUN_BIT]),
    .rd_frst_i   (rd_data_o[acsr_pkg::FIFO_RST_BIT]),
    .rd_ie_i     (rd_data_o[acsr_pkg::IE_LSB +: acsr_pkg::NUM_FLAGS]),
    .rd_flags_i  (rd_data_o[acsr_pkg::FLAG_LSB +: acsr_pkg::NUM_FLAGS]),
    .rd_dma_i    (rd_data_o[acsr_pkg::DMA_EN_BIT]),
    .lvl_wmark_i (lvl_wmark_i),
    .frame_end_i (frame_end_i),
    .run_o       (run_o),
    .fifo_rst_o  (fifo_rst_o),
    .soft_rst_o  (soft_rst_o),
    .dma_req_o   (dma_req_o),
    .irq_o       (irq_o)
);

// File: tb/audio_port_csr_tb.sv
module audio_port_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_ws = 1'b0, ev_se = 1'b0, ev_fe = 1'b0;
    logic        lv_warn = 1'b0, lv_wm = 1'b0, fend = 1'b0;
    logic        run, frst, srst, dreq, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5ns clk = ~clk;

    audio_port_csr dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .ev_word_start_i(ev_ws), .ev_sync_err_i(ev_se),
        .ev_fifo_err_i(ev_fe), .lvl_fifo_warn_i(lv_warn), .lvl_wmark_i(lv_wm),
        .frame_end_i(fend), .run_o(run), .fifo_rst_o(frst), .soft_rst_o(srst),
        .dma_req_o(dreq), .irq_o(irq)
    );

    localparam logic [31:0] IE = 32'h0000_1500; // enables for flags 0, 2, 4

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outputs", {27'b0, run, frst, srst, dreq, irq}, 32'h0);

        // R2 enable field read back
        do_write(IE);
        chk("R2 ie readback", rd_data, IE);

        // R5 level flags follow inputs, writes ignored
        lv_wm = 1'b1;
        step();
        chk("R5 wmark live", {31'b0, rd_data[16]}, 32'h1);
        do_write(IE | 32'h0003_0000);
        chk("R5 write-one ignored", {30'b0, rd_data[17:16]}, 32'h1);
        lv_wm = 1'b0;
        lv_warn = 1'b1;
        step();
        chk("R5 warn live", {30'b0, rd_data[17:16]}, 32'h2);
        lv_warn = 1'b0;
        step();
        chk("R5 level off", {30'b0, rd_data[17:16]}, 32'h0);

        // R3 sticky set and write-one clear; R6 disabled flag raises no irq
        @(negedge clk); ev_se = 1'b1;
        @(negedge clk); ev_se = 1'b0;
        chk("R3 serr set", {31'b0, rd_data[19]}, 32'h1);
        step();
        chk("R6 disabled flag no irq", {31'b0, irq}, 32'h0);
        do_write(IE);
        chk("R3 write-zero keeps", {31'b0, rd_data[19]}, 32'h1);
        do_write(IE | 32'h0008_0000);
        chk("R3 write-one clears", {31'b0, rd_data[19]}, 32'h0);

        // R4 clear and event in the same cycle (flag clear before)
        @(negedge clk); wr_en = 1'b1; wr_data = IE | 32'h0004_0000; ev_fe = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; ev_fe = 1'b0;
        chk("R4 collision from clear", {31'b0, rd_data[18]}, 32'h1);
        // R4 flag already set
        @(negedge clk); wr_en = 1'b1; wr_data = IE | 32'h0004_0000; ev_fe = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; ev_fe = 1'b0;
        chk("R4 collision from set", {31'b0, rd_data[18]}, 32'h1);
        step();
        chk("R6 enabled ferr irq", {31'b0, irq}, 32'h1);
        do_write(IE | 32'h0004_0000);
        chk("R4 plain clear", {31'b0, rd_data[18]}, 32'h0);

        // R7 FIFO reset pulse
        do_write(IE | 32'h0100_0000);
        chk("R7 pulse high", {31'b0, frst}, 32'h1);
        chk("R7 reads zero", {31'b0, rd_data[24]}, 32'h0);
        step();
        chk("R7 pulse one cycle", {31'b0, frst}, 32'h0);

        // R9 run status until frame end
        do_write(IE | 32'h8000_0000);
        chk("R9 run set", {30'b0, run, rd_data[31]}, 32'h3);
        @(negedge clk); fend = 1'b1;
        @(negedge clk); fend = 1'b0;
        chk("R9 frame end ignored while requested", {31'b0, run}, 32'h1);
        do_write(IE);
        repeat (3) step();
        chk("R9 held after request drop", {30'b0, run, rd_data[31]}, 32'h3);
        @(negedge clk); fend = 1'b1;
        @(negedge clk); fend = 1'b0;
        chk("R9 dropped after frame end", {30'b0, run, rd_data[31]}, 32'h0);
        // R9 frame end on the same cycle as the dropping write
        do_write(IE | 32'h8000_0000);
        @(negedge clk); wr_en = 1'b1; wr_data = IE; fend = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; fend = 1'b0;
        chk("R9 same-cycle drop", {31'b0, run}, 32'h0);

        // R10 DMA gating
        do_write(IE | 32'h1);
        lv_wm = 1'b1; #1ns;
        chk("R10 dma on", {31'b0, dreq}, 32'h1);
        lv_wm = 1'b0; #1ns;
        chk("R10 dma off no wmark", {31'b0, dreq}, 32'h0);
        do_write(IE);
        lv_wm = 1'b1; #1ns;
        chk("R10 dma disabled", {31'b0, dreq}, 32'h0);
        lv_wm = 1'b0;

        // R8 soft reset
        @(negedge clk); ev_ws = 1'b1; ev_se = 1'b1; ev_fe = 1'b1;
        @(negedge clk); ev_ws = 1'b0; ev_se = 1'b0; ev_fe = 1'b0;
        do_write(32'h8000_1F01);
        chk("R8 setup", {27'b0, rd_data[20:18], rd_data[31], rd_data[0]}, 32'h1F);
        do_write(32'h8200_1F01);
        chk("R8 soft reset out", {31'b0, srst}, 32'h1);
        step();
        chk("R8 cleared", {28'b0, rd_data[20:18], rd_data[31]}, 32'h0);
        chk("R8 dma enable cleared", {31'b0, rd_data[0]}, 32'h0);
        chk("R8 ie kept", {27'b0, rd_data[12:8]}, 32'h1F);
        @(negedge clk); ev_ws = 1'b1; lv_wm = 1'b1;
        @(negedge clk); ev_ws = 1'b0;
        chk("R8 events ignored", {27'b0, rd_data[20:16]}, 32'h0);
        chk("R8 no dma req", {31'b0, dreq}, 32'h0);
        step();
        chk("R8 no irq", {31'b0, irq}, 32'h0);
        lv_wm = 1'b0;
        do_write(32'h0000_1F00);
        chk("R8 release", {31'b0, srst}, 32'h0);

        // sweep: all enable masks x all flag patterns (R2, R3, R5, R6)
        for (int e = 0; e < 32; e++) begin
            for (int p = 0; p < 32; p++) begin
                do_write(32'h001C_0000 | (32'(e) << 8));
                @(negedge clk);
                lv_wm = p[0]; lv_warn = p[1]; ev_fe = p[2]; ev_se = p[3]; ev_ws = p[4];
                @(negedge clk);
                ev_fe = 1'b0; ev_se = 1'b0; ev_ws = 1'b0;
                chk("R3 R5 sweep flags", {27'b0, rd_data[20:16]}, 32'(p));
                @(negedge clk);
                chk("R6 sweep irq", {31'b0, irq}, {31'b0, |(5'(p) & 5'(e))});
                lv_wm = 1'b0; lv_warn = 1'b0;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule